// File: doc/BRIEF.md
# UART Modem Control and Line Status Block

This block holds the modem-control register and the line-status register of a 16550-style serial port. A byte-wide register bus writes and reads them. The modem-control register drives four general-purpose modem output pins: the data-terminal-ready line, the request-to-send line and two spare outputs. It also holds a loopback switch that folds the serial path and the modem lines back inside the block, so that driver software can test the port without external wiring.

The line-status register gathers status that other parts of the port supply. It reports whether the transmit FIFO is empty and whether the whole transmitter is empty, meaning both the FIFO and the shift register. It also carries a summary error flag that is set while any parity error, framing error or break condition is present. The baud generator, the receive sampler, the FIFOs and the interrupt logic live elsewhere. Plain status and data ports stand in for them here.

The modem-control register sits at offset 4 and the line-status register at offset 5. Any other offset reads as zero.

Top module: `uart_modem_ctl`

## Requirements
- R1: While reset is held, and right after it, both the modem-control register (offset 4) and the line-status register (offset 5) read 0x00.
- R2: A bus write to offset 4 stores data bits 4:0 in the modem-control register. The stored value reads back from the cycle after the write. Bits 7:5 always read 0.
- R3: With modem-control bit 4 clear (normal mode), the pins follow the register: `dtr_o` = bit 0, `rts_o` = bit 1, `out1_o` = bit 2 and `out2_o` = bit 3, all active high. The internal status outputs `sts_dsr_o`, `sts_cts_o`, `sts_ri_o` and `sts_dcd_o` follow the pins `dsr_i`, `cts_i`, `ri_i` and `dcd_i`. `txd_o` equals `tx_bit_i`, and `rx_bit_o` equals `rxd_i`.
- R4: With bit 4 set (loopback), `txd_o` is held at 1, and `rx_bit_o` equals `tx_bit_i`.
- R5: In loopback, `sts_dsr_o` = bit 0 (DTR), `sts_cts_o` = bit 1 (RTS), `sts_ri_o` = bit 2 (OUT1) and `sts_dcd_o` = bit 3 (OUT2). The external modem input pins have no effect.
- R6: In loopback, `dtr_o`, `rts_o`, `out1_o` and `out2_o` are all driven to their inactive level, 0.
- R7: Line-status bit 7 reads 1 from the clock after any of `par_err_i`, `frm_err_i` or `brk_i` is high. It reads 0 from the clock after all three are low.
- R8: Line-status bit 5 holds the value of `txf_empty_i` from the previous clock. It reads 0 after a clock in which `tx_push_i` was high.
- R9: Line-status bit 6 holds `txf_empty_i` AND `tsr_empty_i` from the previous clock. It reads 0 after a clock with `tx_push_i` high, and it is never 1 while bit 5 is 0.
- R10: Bus writes to offset 5 have no effect, line-status bits 4:0 read 0, and offsets other than 4 and 5 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tx_bit_i | input | 1 | Serial output of the transmit shift register |
| txd_o | output | 1 | Serial transmit pin |
| rxd_i | input | 1 | Serial receive pin |
| rx_bit_o | output | 1 | Serial input to the receive shift register |
| dtr_o | output | 1 | Data-terminal-ready pin, active high |
| rts_o | output | 1 | Request-to-send pin, active high |
| out1_o | output | 1 | Spare modem output 1 |
| out2_o | output | 1 | Spare modem output 2 |
| dsr_i | input | 1 | Data-set-ready pin |
| cts_i | input | 1 | Clear-to-send pin |
| ri_i | input | 1 | Ring-indicator pin |
| dcd_i | input | 1 | Carrier-detect pin |
| sts_dsr_o | output | 1 | DSR as seen by the modem-status logic |
| sts_cts_o | output | 1 | CTS as seen by the modem-status logic |
| sts_ri_o | output | 1 | RI as seen by the modem-status logic |
| sts_dcd_o | output | 1 | DCD as seen by the modem-status logic |
| par_err_i | input | 1 | A parity error is present |
| frm_err_i | input | 1 | A framing error is present |
| brk_i | input | 1 | A break condition is present |
| txf_empty_i | input | 1 | Transmit FIFO is empty |
| tsr_empty_i | input | 1 | Transmit shift register is empty |
| tx_push_i | input | 1 | Data is being written into the transmit FIFO this cycle |

## Verification
The bench drives each modem-control bit on its own in both modes. A design that swaps a loopback pairing, for example routing RTS onto DSR, shows the wrong status output, and one that leaves the pins live in loopback shows a pin still high. It toggles the external modem inputs and `rxd_i` while loopback is on, which catches a multiplexer that still passes a pin through. It raises each error source alone and then drops them all, so an error flag that latches or ignores one source fails. It also asserts `tx_push_i` while the FIFO reports empty, which exposes empty flags that miss the write. Writes of all-ones to offset 5 and to reserved MCR bits confirm that neither reaches the readback.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;
  localparam int unsigned BUS_DW   = 8;
  localparam int unsigned BUS_AW   = 3;
  localparam int unsigned N_MDM    = 4;   // modem lines handled by loopback
  localparam int unsigned CTL_W    = 5;   // implemented modem-control bits
  localparam int unsigned LOOP_BIT = 4;
  localparam int unsigned LS_ERR   = 7;
  localparam int unsigned LS_TEMT  = 6;
  localparam int unsigned LS_TFE   = 5;
  localparam logic [BUS_AW-1:0] OFS_MCR = 3'd4;
  localparam logic [BUS_AW-1:0] OFS_LSR = 3'd5;
  localparam logic [BUS_DW-1:0] MCR_MASK = BUS_DW'((1 << CTL_W) - 1);
endpackage

// File: rtl/uart_mdm_ctlreg.sv
module uart_mdm_ctlreg
  import uart_mdm_pkg::*;
#(
  parameter logic [BUS_AW-1:0] ADDR = OFS_MCR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  output logic [BUS_DW-1:0] mcr_q,
  output logic [N_MDM-1:0]  line_ctl,
  output logic              loop_en
);
  logic              hit;
  logic [BUS_DW-1:0] mcr_d;

  always_comb begin
    hit   = wr_en && (addr == ADDR);
    mcr_d = mcr_q;
    if (hit) mcr_d = wdata & MCR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mcr_q <= '0;
    else if (hit) mcr_q <= mcr_d;
  end

  assign line_ctl = mcr_q[N_MDM-1:0];
  assign loop_en  = mcr_q[LOOP_BIT];
endmodule

// File: rtl/uart_mdm_loop.sv
module uart_mdm_loop
  import uart_mdm_pkg::*;
(
  input  logic             loop_en,
  input  logic [N_MDM-1:0] line_ctl,
  input  logic [N_MDM-1:0] pin_in,
  output logic [N_MDM-1:0] pin_out,
  output logic [N_MDM-1:0] sts_in,
  input  logic             tx_bit,
  output logic             txd,
  input  logic             rxd,
  output logic             rx_bit
);
  for (genvar i = 0; i < N_MDM; i++) begin : g_line
    always_comb begin
      if (loop_en) begin
        pin_out[i] = 1'b0;
        sts_in[i]  = line_ctl[i];
      end else begin
        pin_out[i] = line_ctl[i];
        sts_in[i]  = pin_in[i];
      end
    end
  end

  always_comb begin
    txd    = loop_en ? 1'b1   : tx_bit;
    rx_bit = loop_en ? tx_bit : rxd;
  end
endmodule

// File: rtl/uart_mdm_lsr.sv
module uart_mdm_lsr
  import uart_mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              brk,
  input  logic              txf_empty,
  input  logic              tsr_empty,
  input  logic              tx_push,
  output logic [BUS_DW-1:0] lsr_q
);
  logic [BUS_DW-1:0] lsr_d;

  always_comb begin
    lsr_d          = '0;
    lsr_d[LS_ERR]  = par_err | frm_err | brk;
    lsr_d[LS_TFE]  = txf_empty & ~tx_push;
    lsr_d[LS_TEMT] = txf_empty & tsr_empty & ~tx_push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lsr_q <= '0;
    else        lsr_q <= lsr_d;
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tx_bit_i,
  output logic       txd_o,
  input  logic       rxd_i,
  output logic       rx_bit_o,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o,
  input  logic       dsr_i,
  input  logic       cts_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       sts_dsr_o,
  output logic       sts_cts_o,
  output logic       sts_ri_o,
  output logic       sts_dcd_o,
  input  logic       par_err_i,
  input  logic       frm_err_i,
  input  logic       brk_i,
  input  logic       txf_empty_i,
  input  logic       tsr_empty_i,
  input  logic       tx_push_i
);
  logic [BUS_DW-1:0] mcr_q;
  logic [BUS_DW-1:0] lsr_q;
  logic [N_MDM-1:0]  line_ctl;
  logic [N_MDM-1:0]  pin_out;
  logic [N_MDM-1:0]  sts_in;
  logic              loop_en;

  uart_mdm_ctlreg #(.ADDR(OFS_MCR)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .mcr_q(mcr_q), .line_ctl(line_ctl), .loop_en(loop_en)
  );

  uart_mdm_loop u_loop (
    .loop_en(loop_en), .line_ctl(line_ctl),
    .pin_in({dcd_i, ri_i, cts_i, dsr_i}),
    .pin_out(pin_out), .sts_in(sts_in),
    .tx_bit(tx_bit_i), .txd(txd_o), .rxd(rxd_i), .rx_bit(rx_bit_o)
  );

  uart_mdm_lsr u_lsr (
    .clk(clk), .rst_n(rst_n), .par_err(par_err_i), .frm_err(frm_err_i),
    .brk(brk_i), .txf_empty(txf_empty_i), .tsr_empty(tsr_empty_i),
    .tx_push(tx_push_i), .lsr_q(lsr_q)
  );

  assign {out2_o, out1_o, rts_o, dtr_o}             = pin_out;
  assign {sts_dcd_o, sts_ri_o, sts_cts_o, sts_dsr_o} = sts_in;

  always_comb begin
    unique case (bus_addr)
      OFS_MCR: bus_rdata = mcr_q;
      OFS_LSR: bus_rdata = lsr_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       loop_en,
  input logic [7:0] mcr_q,
  input logic [7:0] lsr_q,
  input logic       tx_bit_i,
  input logic       txd_o,
  input logic       rxd_i,
  input logic       rx_bit_o,
  input logic       dtr_o,
  input logic       rts_o,
  input logic       out1_o,
  input logic       out2_o,
  input logic       dsr_i,
  input logic       sts_dsr_o,
  input logic       sts_cts_o,
  input logic       sts_ri_o,
  input logic       sts_dcd_o,
  input logic       par_err_i,
  input logic       frm_err_i,
  input logic       brk_i,
  input logic       txf_empty_i,
  input logic       tx_push_i
);
  assert_mcr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd4) |=> mcr_q == ($past(bus_wdata) & 8'h1F));

  assert_mcr_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4) |-> bus_rdata[7:5] == 3'b000);

  assert_normal_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (dtr_o == mcr_q[0] && sts_dsr_o == dsr_i && txd_o == tx_bit_i
                  && rx_bit_o == rxd_i));

  assert_loop_serial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (txd_o && rx_bit_o == tx_bit_i));

  assert_loop_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (sts_dsr_o == mcr_q[0] && sts_cts_o == mcr_q[1]
                 && sts_ri_o == mcr_q[2] && sts_dcd_o == mcr_q[3]));

  assert_loop_pins_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> $countones({dtr_o, rts_o, out1_o, out2_o}) == 0);

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_i || frm_err_i || brk_i) |=> lsr_q[7]);

  assert_err_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_err_i || frm_err_i || brk_i) |=> !lsr_q[7]);

  assert_push_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_i |=> (!lsr_q[5] && !lsr_q[6]));

  assert_tfe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_push_i && txf_empty_i) |=> lsr_q[5]);

  assert_temt_implies_tfe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_q[6] |-> lsr_q[5]);

  assert_lsr_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_q[4:0] == 5'd0);
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .loop_en(loop_en),
  .mcr_q(mcr_q), .lsr_q(lsr_q), .tx_bit_i(tx_bit_i), .txd_o(txd_o),
  .rxd_i(rxd_i), .rx_bit_o(rx_bit_o), .dtr_o(dtr_o), .rts_o(rts_o),
  .out1_o(out1_o), .out2_o(out2_o), .dsr_i(dsr_i), .sts_dsr_o(sts_dsr_o),
  .sts_cts_o(sts_cts_o), .sts_ri_o(sts_ri_o), .sts_dcd_o(sts_dcd_o),
  .par_err_i(par_err_i), .frm_err_i(frm_err_i), .brk_i(brk_i),
  .txf_empty_i(txf_empty_i), .tx_push_i(tx_push_i)
);

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic tx_bit_i, txd_o, rxd_i, rx_bit_o;
  logic dtr_o, rts_o, out1_o, out2_o;
  logic dsr_i, cts_i, ri_i, dcd_i;
  logic sts_dsr_o, sts_cts_o, sts_ri_o, sts_dcd_o;
  logic par_err_i, frm_err_i, brk_i, txf_empty_i, tsr_empty_i, tx_push_i;

  uart_modem_ctl u_uart_modem_ctl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Observation points: 0 = read data, 1 = {out2,out1,rts,dtr},
  // 2 = {dcd,ri,cts,dsr} status, 3 = {rx_bit,txd}
  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return bus_rdata;
      1: return {4'd0, out2_o, out1_o, rts_o, dtr_o};
      2: return {4'd0, sts_dcd_o, sts_ri_o, sts_cts_o, sts_dsr_o};
      default: return {6'd0, rx_bit_o, txd_o};
    endcase
  endfunction

  // Monitor: compares pending expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = observe(it.sel);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(int sel, logic [7:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic read_exp(logic [2:0] a, logic [7:0] exp, string tag);
    bus_addr = a;
    expect_val(0, exp, tag);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 3'd4; bus_wr = 1'b0; bus_wdata = '0;
    tx_bit_i = 1'b0; rxd_i = 1'b1;
    dsr_i = 1'b0; cts_i = 1'b0; ri_i = 1'b0; dcd_i = 1'b0;
    par_err_i = 1'b0; frm_err_i = 1'b0; brk_i = 1'b0;
    txf_empty_i = 1'b1; tsr_empty_i = 1'b1; tx_push_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    read_exp(3'd4, 8'h00, "R1 mcr in reset");
    read_exp(3'd5, 8'h00, "R1 lsr in reset");
    rst_n = 1'b1;

    // R2: write and readback, reserved bits masked
    bus_write(3'd4, 8'hEA);
    read_exp(3'd4, 8'h0A, "R2 mcr readback, reserved 7:5 zero");
    bus_write(3'd4, 8'h05);
    read_exp(3'd4, 8'h05, "R2 mcr second value");

    // R3: normal mode, each control bit alone
    for (int i = 0; i < 4; i++) begin
      bus_write(3'd4, 8'(1 << i));
      expect_val(1, 8'(1 << i), "R3 pin follows control bit");
    end
    dsr_i = 1'b1; cts_i = 1'b0; ri_i = 1'b1; dcd_i = 1'b0;
    expect_val(2, 8'h05, "R3 status follows pins");
    tx_bit_i = 1'b0; rxd_i = 1'b1;
    expect_val(3, 8'h02, "R3 serial straight through");

    // R4/R5/R6: loopback
    bus_write(3'd4, 8'h13);  // loop + dtr + rts
    expect_val(1, 8'h00, "R6 pins idle in loopback");
    expect_val(2, 8'h03, "R5 dsr<-dtr cts<-rts");
    dsr_i = 1'b0; cts_i = 1'b0; ri_i = 1'b1; dcd_i = 1'b1;
    expect_val(2, 8'h03, "R5 external pins ignored");
    tx_bit_i = 1'b0; rxd_i = 1'b1;
    expect_val(3, 8'h01, "R4 txd high, rx from tx (0)");
    tx_bit_i = 1'b1; rxd_i = 1'b0;
    expect_val(3, 8'h03, "R4 rx from tx (1)");
    for (int i = 0; i < 4; i++) begin
      bus_write(3'd4, 8'h10 | 8'(1 << i));
      expect_val(2, 8'(1 << i), "R5 loop mapping per line");
      expect_val(1, 8'h00, "R6 pin stays idle");
    end
    bus_write(3'd4, 8'h00);
    dsr_i = 1'b0; cts_i = 1'b1; ri_i = 1'b0; dcd_i = 1'b1;
    expect_val(2, 8'h0A, "R3 pins live again after loopback");

    // R7: error summary
    bus_addr = 3'd5;
    txf_empty_i = 1'b1; tsr_empty_i = 1'b1;
    tick();
    read_exp(3'd5, 8'h60, "R9 both empty");
    par_err_i = 1'b1; tick();
    read_exp(3'd5, 8'hE0, "R7 parity error sets flag");
    par_err_i = 1'b0; tick();
    read_exp(3'd5, 8'h60, "R7 flag clears with source");
    frm_err_i = 1'b1; tick();
    read_exp(3'd5, 8'hE0, "R7 framing error");
    frm_err_i = 1'b0; brk_i = 1'b1; tick();
    read_exp(3'd5, 8'hE0, "R7 break");
    brk_i = 1'b0; tick();
    read_exp(3'd5, 8'h60, "R7 all clear");

    // R8/R9: transmit empty flags
    tsr_empty_i = 1'b0; tick();
    read_exp(3'd5, 8'h20, "R9 shift reg busy, FIFO empty");
    tsr_empty_i = 1'b1; tx_push_i = 1'b1; tick();
    read_exp(3'd5, 8'h00, "R8 push clears both empty flags");
    tx_push_i = 1'b0; txf_empty_i = 1'b0; tick();
    read_exp(3'd5, 8'h00, "R8 FIFO holds data");
    txf_empty_i = 1'b1; tick();
    read_exp(3'd5, 8'h60, "R8 FIFO drained");

    // R10: writes to LSR ignored, other offsets zero
    bus_write(3'd5, 8'hFF);
    read_exp(3'd5, 8'h60, "R10 lsr write ignored");
    read_exp(3'd4, 8'h00, "R10 lsr write leaves mcr");
    read_exp(3'd0, 8'h00, "R10 unmapped offset");
    bus_write(3'd4, 8'h1F);
    read_exp(3'd7, 8'h00, "R10 unmapped offset 7");
    read_exp(3'd4, 8'h1F, "R2 all implemented bits");

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule